// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between a load/store unit and a bus controller. It takes one operand request at a time: byte, word or long word, read or write. It turns a non-cachable data operand that does not sit on its natural boundary into a short series of naturally aligned bus transfers. Transfers go out in ascending address order. For a read, the block merges the returned pieces into one result. For a write, it steers the right operand bytes onto each transfer.

Cachable requests and instruction fetches at even addresses go downstream as a single transfer, unchanged, so that a line fill can deal with them. An instruction fetch at an odd address never reaches the bus. It completes with an address-error flag, and exception handling is left to the requester. Byte order is big-endian: the most significant operand byte lives at the lowest address.

Top module: `misalign_splitter`

## Requirements
- R1: A byte operand (size code 0) is always sent as one byte transfer (bus size code 0) at the requested address.
- R2: A non-cachable data word (size code 1) at an odd address is sent as two byte transfers, at A and then at A+1.
- R3: A non-cachable data long word (size code 2; code 3 is handled as a long word) is split by its address bits [1:0]:
  - At offset 1 or 3 it becomes a byte at A, a word at A+1 and a byte at A+3.
  - At offset 2 it becomes a word at A and a word at A+2.
- R4: Every transfer issued for non-cachable data is aligned, meaning a word has address bit 0 clear and a long word has bits [1:0] clear. A data operand that is already aligned goes out as one transfer of its own size.
- R5: A cachable request goes out as exactly one transfer with the original address and size, even when it is misaligned.
- R6: An instruction fetch at an odd address issues no transfer. The response, with the address-error flag set, follows one cycle after acceptance. An instruction fetch at an even address goes out as one unchanged transfer.
- R7: The write operand is right-justified in `req_wdata`. Each transfer carries the next most significant unsent operand bytes, right-justified in `bus_wdata` (a byte in [7:0], a word in [15:0]).
- R8: Returned data is taken right-justified from `bus_rdata`. The read result is presented right-justified in `rsp_rdata`, with the bytes from the lowest address most significant.
- R9: `req_ready` is high only when the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the response.
  - `rsp_valid` is a one-cycle pulse in the cycle after the final acknowledge.
  - `req_ready` returns high in the cycle after that pulse.
- R10: A transfer acknowledged with `bus_berr` high ends the sequence, and no further transfer follows. The response comes in the next cycle with `rsp_berr` set, reported once.
- R11: Address, size and write data of a transfer stay stable while `bus_valid` is high and `bus_ack` is low. A transfer completes on a clock edge where `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Block idle, request accepted this edge |
| req_addr | input | AW | Operand byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Right-justified write operand |
| req_cachable | input | 1 | Request is cachable |
| req_ifetch | input | 1 | Request is an instruction fetch |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-justified merged read result |
| rsp_berr | output | 1 | A piece ended in bus error |
| rsp_aerr | output | 1 | Odd instruction-fetch address error |
| bus_valid | output | 1 | Transfer present |
| bus_addr | output | AW | Transfer address |
| bus_size | output | 2 | 0 byte, 1 word, 2 long word |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Right-justified transfer write data |
| bus_cachable | output | 1 | Copy of the request's cachable flag |
| bus_ifetch | output | 1 | Copy of the request's fetch flag |
| bus_ack | input | 1 | Transfer completes this edge |
| bus_berr | input | 1 | Qualified by bus_ack: transfer failed |
| bus_rdata | input | 32 | Right-justified transfer read data |

## Verification
Timing of each result:
- The first piece appears on the bus in the cycle after acceptance.
- Each later piece appears in the cycle after the acknowledge of the one before it.
- The response pulse comes one cycle after the final or failing acknowledge.
- An odd-fetch address error responds one cycle after acceptance.

The bench keeps a behavioural model that advances on the same rising edge as the design, using the inputs sampled there. It compares every output against that model at the following falling edge, so each expected value is checked in exactly the cycle it is due. The bus responder varies acknowledge latency from zero to two wait cycles, and it injects bus errors on chosen pieces.

// File: rtl/misalign_splitter.sv
module misalign_splitter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic          req_cachable,
  input  logic          req_ifetch,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_berr,
  output logic          rsp_aerr,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [31:0]   bus_wdata,
  output logic          bus_cachable,
  output logic          bus_ifetch,
  input  logic          bus_ack,
  input  logic          bus_berr,
  input  logic [31:0]   bus_rdata
);

  typedef enum logic [1:0] {IDLE, BUS, RSP} state_t;

  state_t        st;
  logic [AW-1:0] addr_q;
  logic [2:0]    rem;
  logic [2:0]    pc;
  logic [2:0]    nb_req;
  logic [31:0]   wbuf, rbuf, wjust;
  logic          wr_q, cach_q, if_q, berr_q, aerr_q;

  always_comb begin
    case (req_size)
      2'd0:    begin nb_req = 3'd1; wjust = {req_wdata[7:0], 24'b0};  end
      2'd1:    begin nb_req = 3'd2; wjust = {req_wdata[15:0], 16'b0}; end
      default: begin nb_req = 3'd4; wjust = req_wdata;                end
    endcase
  end

  always_comb begin
    if (cach_q || if_q)                         pc = rem;
    else if (rem == 3'd1 || addr_q[0])          pc = 3'd1;
    else if (rem == 3'd4 && addr_q[1:0] == 2'b00) pc = 3'd4;
    else                                        pc = 3'd2;
  end

  assign req_ready    = (st == IDLE);
  assign rsp_valid    = (st == RSP);
  assign rsp_rdata    = rbuf;
  assign rsp_berr     = berr_q;
  assign rsp_aerr     = aerr_q;
  assign bus_valid    = (st == BUS);
  assign bus_addr     = addr_q;
  assign bus_size     = (pc == 3'd1) ? 2'd0 : (pc == 3'd2) ? 2'd1 : 2'd2;
  assign bus_write    = wr_q;
  assign bus_cachable = cach_q;
  assign bus_ifetch   = if_q;
  assign bus_wdata    = (pc == 3'd1) ? {24'b0, wbuf[31:24]} :
                        (pc == 3'd2) ? {16'b0, wbuf[31:16]} : wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      addr_q <= '0;
      rem    <= '0;
      wbuf   <= '0;
      rbuf   <= '0;
      wr_q   <= 1'b0;
      cach_q <= 1'b0;
      if_q   <= 1'b0;
      berr_q <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem    <= nb_req;
          wbuf   <= wjust;
          rbuf   <= '0;
          wr_q   <= req_write;
          cach_q <= req_cachable;
          if_q   <= req_ifetch;
          berr_q <= 1'b0;
          aerr_q <= req_ifetch && req_addr[0];
          st     <= (req_ifetch && req_addr[0]) ? RSP : BUS;
        end
        BUS: if (bus_ack) begin
          addr_q <= addr_q + AW'(pc);
          rem    <= rem - pc;
          wbuf   <= (pc == 3'd1) ? {wbuf[23:0], 8'b0} :
                    (pc == 3'd2) ? {wbuf[15:0], 16'b0} : 32'b0;
          if (!wr_q)
            rbuf <= (pc == 3'd1) ? {rbuf[23:0], bus_rdata[7:0]} :
                    (pc == 3'd2) ? {rbuf[15:0], bus_rdata[15:0]} : bus_rdata;
          if (bus_berr) begin
            berr_q <= 1'b1;
            st     <= RSP;
          end else if (rem == pc) begin
            st     <= RSP;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/misalign_splitter_chk.sv
module misalign_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          req_cachable,
  input logic          req_ifetch,
  input logic          rsp_valid,
  input logic          rsp_berr,
  input logic          rsp_aerr,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [31:0]   bus_wdata,
  input logic          bus_cachable,
  input logic          bus_ifetch,
  input logic          bus_ack,
  input logic          bus_berr
);

  function automatic logic [AW-1:0] span(input logic [1:0] s);
    return (s == 2'd0) ? AW'(1) : (s == 2'd1) ? AW'(2) : AW'(4);
  endfunction

  function automatic logic [1:0] norm(input logic [1:0] s);
    return (s == 2'd3) ? 2'd2 : s;
  endfunction

  AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_size == 2'd0 && !(req_ifetch && req_addr[0])
    |=> bus_valid && bus_size == 2'd0 && bus_addr == $past(req_addr)); // R1

  AST_PIECE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_cachable && !bus_ifetch
    |-> bus_size == 2'd0 || (bus_size == 2'd1 && !bus_addr[0]) || bus_addr[1:0] == 2'b00); // R4

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack && !bus_berr
    |=> !bus_valid || bus_addr == $past(bus_addr) + span($past(bus_size))); // R3

  AST_CACHABLE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_cachable && !(req_ifetch && req_addr[0])
    |=> bus_valid && bus_addr == $past(req_addr) && bus_size == norm($past(req_size))); // R5

  AST_ODD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_ifetch && req_addr[0]
    |=> rsp_valid && rsp_aerr && !bus_valid); // R6

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready); // R9

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R9

  AST_BERR_END: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ack && bus_berr |=> rsp_valid && rsp_berr && !bus_valid); // R10

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack
    |=> bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata)); // R11

endmodule

bind misalign_splitter misalign_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .req_cachable(req_cachable),
  .req_ifetch(req_ifetch), .rsp_valid(rsp_valid), .rsp_berr(rsp_berr),
  .rsp_aerr(rsp_aerr), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_cachable(bus_cachable),
  .bus_ifetch(bus_ifetch), .bus_ack(bus_ack), .bus_berr(bus_berr)
);

// File: tb/sim_misalign_splitter.sv
module sim_misalign_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write, req_cachable, req_ifetch;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_berr, rsp_aerr;
  logic [31:0]   rsp_rdata;
  logic          bus_valid, bus_write, bus_cachable, bus_ifetch, bus_ack, bus_berr;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata, bus_rdata;

  misalign_splitter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_cachable(req_cachable), .req_ifetch(req_ifetch),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_berr(rsp_berr),
    .rsp_aerr(rsp_aerr), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_cachable(bus_cachable), .bus_ifetch(bus_ifetch), .bus_ack(bus_ack),
    .bus_berr(bus_berr), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    nchk = 0, nfail = 0;
  string tag = "R9";
  int    ack_delay = 0, berr_at = -1, piece_idx = 0, wcnt = 0;

  function automatic logic [7:0] memb(input logic [31:0] a);
    return 8'(a * 32'd13 + 32'd7);
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          ph = 0;
  int          q_off[$], q_len[$];
  int          m_n;
  logic [31:0] m_base, m_wd, m_rd;
  bit          m_wr, m_cach, m_if, m_berr, m_aerr;

  function automatic logic [31:0] piece_wd(input int off, input int len);
    logic [31:0] r = 0;
    for (int j = 0; j < len; j++)
      r = (r << 8) | ((m_wd >> (8 * (m_n - 1 - off - j))) & 32'hFF);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
        m_n = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
        m_base = req_addr; m_wd = req_wdata; m_wr = req_write;
        m_cach = req_cachable; m_if = req_ifetch; m_berr = 0; m_aerr = 0;
        q_off.delete(); q_len.delete();
        m_rd = 0;
        for (int i = 0; i < m_n; i++) m_rd = (m_rd << 8) | 32'(memb(req_addr + 32'(i)));
        if (req_ifetch && req_addr[0]) begin
          m_aerr = 1; ph = 2;
        end else begin
          if (m_cach || m_if || m_n == 1 || (m_n == 2 && !req_addr[0]) ||
              (m_n == 4 && req_addr[1:0] == 2'b00)) begin
            q_off.push_back(0); q_len.push_back(m_n);
          end else if (m_n == 2) begin
            q_off.push_back(0); q_len.push_back(1);
            q_off.push_back(1); q_len.push_back(1);
          end else if (req_addr[1:0] == 2'd2) begin
            q_off.push_back(0); q_len.push_back(2);
            q_off.push_back(2); q_len.push_back(2);
          end else begin
            q_off.push_back(0); q_len.push_back(1);
            q_off.push_back(1); q_len.push_back(2);
            q_off.push_back(3); q_len.push_back(1);
          end
          ph = 1;
        end
      end
      1: if (bus_ack) begin
        void'(q_off.pop_front()); void'(q_len.pop_front());
        if (bus_berr) begin m_berr = 1; ph = 2; end
        else if (q_off.size() == 0) ph = 2;
      end
      default: ph = 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    chk("req_ready", 64'(req_ready), 64'(ph == 0));
    chk("bus_valid", 64'(bus_valid), 64'(ph == 1));
    chk("rsp_valid", 64'(rsp_valid), 64'(ph == 2));
    if (ph == 1 && bus_valid && q_off.size() > 0) begin
      chk("bus_addr", 64'(bus_addr), 64'(m_base + 32'(q_off[0])));
      chk("bus_size", 64'(bus_size), 64'(q_len[0] == 1 ? 0 : q_len[0] == 2 ? 1 : 2));
      chk("bus_write", 64'(bus_write), 64'(m_wr));
      chk("bus_cachable", 64'(bus_cachable), 64'(m_cach));
      chk("bus_ifetch", 64'(bus_ifetch), 64'(m_if));
      if (m_wr) chk("bus_wdata", 64'(bus_wdata), 64'(piece_wd(q_off[0], q_len[0])));
    end
    if (ph == 2 && rsp_valid) begin
      chk("rsp_aerr", 64'(rsp_aerr), 64'(m_aerr));
      chk("rsp_berr", 64'(rsp_berr), 64'(m_berr));
      if (!m_wr && !m_berr && !m_aerr) chk("rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
    end
  end

  // bus responder
  always @(negedge clk) begin
    if (bus_valid) begin
      if (wcnt >= ack_delay) begin
        int n;
        logic [31:0] v;
        n = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
        v = 0;
        for (int i = 0; i < n; i++) v = (v << 8) | 32'(memb(bus_addr + 32'(i)));
        bus_rdata = (n == 4) ? v : ((32'hA5A5A5A5 << (8 * n)) | v);
        bus_ack = 1'b1;
        bus_berr = (piece_idx == berr_at);
        piece_idx++;
        wcnt = 0;
      end else begin
        bus_ack = 1'b0; bus_berr = 1'b0; wcnt++;
      end
    end else begin
      bus_ack = 1'b0; bus_berr = 1'b0;
    end
  end

  task automatic do_op(input string t, input logic [31:0] a, input logic [1:0] sz,
                       input bit wr, input bit c, input bit f, input int dly, input int be);
    @(negedge clk);
    tag = t; ack_delay = dly; berr_at = be; piece_idx = 0; wcnt = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = $urandom; req_cachable = c; req_ifetch = f;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_wdata = '0; req_cachable = 1'b0; req_ifetch = 1'b0;
    bus_ack = 1'b0; bus_berr = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R9";
    chk("reset req_ready", 64'(req_ready), 64'd1);
    chk("reset bus_valid", 64'(bus_valid), 64'd0);
    chk("reset rsp_valid", 64'(rsp_valid), 64'd0);
    // R1 bytes
    do_op("R1", 32'h101, 2'd0, 0, 0, 0, 0, -1);
    do_op("R1", 32'h103, 2'd0, 1, 0, 0, 1, -1);
    // R2 odd words
    do_op("R2", 32'h201, 2'd1, 0, 0, 0, 0, -1);
    do_op("R2", 32'h203, 2'd1, 1, 0, 0, 2, -1);
    // R3 long words at each misaligned offset
    do_op("R3", 32'h301, 2'd2, 0, 0, 0, 0, -1);
    do_op("R3", 32'h302, 2'd2, 0, 0, 0, 1, -1);
    do_op("R3", 32'h303, 2'd3, 0, 0, 0, 0, -1);
    // R4 aligned operands
    do_op("R4", 32'h400, 2'd1, 0, 0, 0, 0, -1);
    do_op("R4", 32'h404, 2'd2, 1, 0, 0, 0, -1);
    // R5 cachable passthrough
    do_op("R5", 32'h501, 2'd2, 0, 1, 0, 0, -1);
    do_op("R5", 32'h503, 2'd1, 1, 1, 0, 1, -1);
    // R6 instruction fetches
    do_op("R6", 32'h601, 2'd1, 0, 0, 1, 0, -1);
    do_op("R6", 32'h602, 2'd2, 0, 0, 1, 0, -1);
    // R7 write steering, R8 read merge
    do_op("R7", 32'h701, 2'd2, 1, 0, 0, 0, -1);
    do_op("R7", 32'h703, 2'd2, 1, 0, 0, 1, -1);
    do_op("R7", 32'h706, 2'd2, 1, 0, 0, 0, -1);
    do_op("R8", 32'h801, 2'd2, 0, 0, 0, 2, -1);
    do_op("R8", 32'h807, 2'd1, 0, 0, 0, 1, -1);
    // R10 bus errors
    do_op("R10", 32'hA01, 2'd2, 0, 0, 0, 0, 1);
    do_op("R10", 32'hA03, 2'd2, 1, 0, 0, 1, 0);
    do_op("R10", 32'hA06, 2'd2, 0, 0, 0, 0, 1);
    // R11 long waits
    do_op("R11", 32'hB01, 2'd2, 1, 0, 0, 2, -1);
    for (int i = 0; i < 40; i++)
      do_op("R4", 32'h1000 + ($urandom % 256), 2'($urandom % 3), 1'($urandom % 2),
            ($urandom % 4) == 0, ($urandom % 8) == 0, int'($urandom % 3), -1);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule